// File: doc/BRIEF.md
# E1 Timeslot-0 S1 Byte Extractor

This block recovers the synchronization status byte that a 2048 kbit/s E1 stream carries in the spare national bits of timeslot 0. A framer upstream supplies each timeslot-0 octet with a strobe. It also supplies a flag that tells whether the frame is one without the frame alignment word, a marker for the first frame of each multiframe, and a multiframe lock indication. The block takes one configurable spare bit from each eligible frame and shifts eight such samples into an S1 byte, with the first sample becoming the most significant bit.

The lower nibble of the assembled byte is the clock quality level. This value drives reference selection, and one corrupted multiframe could trigger a needless switchover. For that reason the nibble is published only after the same value has arrived in three consecutive complete multiframes. When lock is lost, the partial byte is dropped and the published level is marked invalid. The level becomes valid again only after it has been confirmed afresh.

Top module: `s1_extract`

## Requirements
- R1: After reset, `ql_valid`, `s1_new` and `s1_byte` are all 0.
- R2: `sa_select` values 0, 1, 2, 3 and 4 pick the spare bit Sa4, Sa5, Sa6, Sa7 and Sa8. These are octet bits 4 to 8, counted with bit 1 as `ts0_octet[7]`, so they sit at `ts0_octet[4]` down to `ts0_octet[0]`. Values 5 to 7 fall back to Sa4.
- R3: A sample is taken only from a strobed octet with `ts0_nfas`=1. Octets with `ts0_nfas`=0 contribute nothing.
- R4: After a `mf_start` strobe, the first sample lands in `s1_byte[7]` and the eighth in `s1_byte[0]`. `s1_byte` updates and `s1_new` pulses for one cycle on the clock edge that accepts the eighth sample. Any further samples before the next `mf_start` are ignored.
- R5: The quality nibble is `s1_byte[3:0]`, which holds S1 bits 5 to 8.
- R6: `ql` takes a nibble value, and `ql_valid` rises, on the edge that completes the third consecutive complete multiframe carrying that same nibble. After one or two such multiframes nothing is published.
- R7: While a differing nibble is still unconfirmed, the previously published `ql` and `ql_valid` stay as they were.
- R8: While `mf_locked`=0, `ql_valid` is 0 from the next edge on. The partial byte and the match history are discarded, and sampling resumes only after the next `mf_start`.
- R9: A `mf_start` that arrives before eight samples have been taken discards the partial byte. It leaves `s1_byte`, `ql`, `ql_valid` and the match history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts0_valid | input | 1 | Strobe: `ts0_octet` holds a timeslot-0 octet |
| ts0_octet | input | 8 | Timeslot-0 octet, bit 1 at index 7 |
| ts0_nfas | input | 1 | The octet belongs to a frame without the alignment word |
| mf_start | input | 1 | The octet belongs to the first frame of a multiframe |
| mf_locked | input | 1 | Multiframe alignment is held |
| sa_select | input | 3 | Spare bit selection (0 = Sa4 … 4 = Sa8) |
| s1_byte | output | 8 | Last complete S1 byte |
| s1_new | output | 1 | One-cycle pulse when `s1_byte` updates |
| ql | output | 4 | Confirmed quality level |
| ql_valid | output | 1 | `ql` has been confirmed since the last loss of lock |

## Verification
A wrong sample counter or a wrong armed flag shows up at the ports within one multiframe. Either `s1_new` pulses at the wrong octet, or `s1_byte` arrives rotated or carrying bits from octets that have the alignment word. A corrupted match counter or candidate nibble surfaces within three multiframes: `ql_valid` rises one multiframe early or late, or `ql` switches on an unconfirmed value. An alignment flag that was not cleared appears on the first edge after lock drops, because `ql_valid` stays high.

// File: rtl/s1x_pkg.sv
package s1x_pkg;
    localparam int S1_W      = 8;  // bits per status byte
    localparam int QL_W      = 4;  // quality nibble width
    localparam int OCT_W     = 8;  // timeslot-0 octet width
    localparam int SA_COUNT  = 5;  // Sa4..Sa8
    localparam int SA_TOP    = 4;  // octet index of Sa4 (bit 4 counted from MSB = 1)
    localparam int SEL_W     = 3;
    localparam int CONFIRM_N = 3;  // consecutive equal multiframes before publishing
endpackage

// File: rtl/s1x_sa_pick.sv
module s1x_sa_pick
    import s1x_pkg::*;
#(
    parameter int NUM_SA  = SA_COUNT,
    parameter int TOP_IDX = SA_TOP,
    parameter int SW      = SEL_W
) (
    input  logic [TOP_IDX:0] sa_field,
    input  logic [SW-1:0]    sel,
    output logic             sa_bit
);
    logic [NUM_SA-1:0] opts;

    // opts[k] holds spare bit Sa(4+k)
    for (genvar k = 0; k < NUM_SA; k++) begin : g_opt
        assign opts[k] = sa_field[TOP_IDX - k];
    end

    always_comb begin
        sa_bit = opts[0];
        for (int k = 1; k < NUM_SA; k++) begin
            if (sel == SW'(k)) sa_bit = opts[k];
        end
    end
endmodule

// File: rtl/s1x_assembler.sv
module s1x_assembler
    import s1x_pkg::*;
#(
    parameter int SAMPLES = S1_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_en,
    input  logic               sample_bit,
    input  logic               start_en,
    input  logic               mf_locked,
    output logic               done_o,
    output logic [SAMPLES-1:0] byte_o,
    output logic [SAMPLES-1:0] s1_byte_o,
    output logic               s1_new_o
);
    localparam int CW = $clog2(SAMPLES + 1);

    typedef struct packed {
        logic               armed;
        logic [CW-1:0]      cnt;
        logic [SAMPLES-1:0] sh;
        logic [SAMPLES-1:0] s1;
        logic               fresh;
    } asm_t;

    asm_t st_d, st_q;
    logic [SAMPLES-1:0] shifted;

    always_comb begin
        st_d    = st_q;
        st_d.fresh = 1'b0;
        done_o  = 1'b0;
        shifted = {st_q.sh[SAMPLES-2:0], sample_bit};
        if (!mf_locked) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (start_en) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (sample_en && st_q.armed && st_q.cnt < CW'(SAMPLES)) begin
            st_d.sh  = shifted;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(SAMPLES - 1)) begin
                done_o     = 1'b1;
                st_d.s1    = shifted;
                st_d.fresh = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_o    = shifted;
    assign s1_byte_o = st_q.s1;
    assign s1_new_o  = st_q.fresh;

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(SAMPLES));
    a_r3_new_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        s1_new_o |-> $past(sample_en));
    a_r8_unlock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_locked |=> !s1_new_o);
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (start_en && mf_locked) |=> (st_q.cnt == '0 && $stable(s1_byte_o)));
endmodule

// File: rtl/s1x_confirm.sv
module s1x_confirm
    import s1x_pkg::*;
#(
    parameter int QW   = QL_W,
    parameter int CONF = CONFIRM_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [QW-1:0] nib_i,
    input  logic          mf_locked,
    output logic [QW-1:0] ql_o,
    output logic          ql_valid_o
);
    localparam int RW = $clog2(CONF + 1);

    typedef struct packed {
        logic [QW-1:0] cand;
        logic [RW-1:0] run;
        logic [QW-1:0] ql;
        logic          vld;
    } cf_t;

    cf_t cf_d, cf_q;

    always_comb begin
        cf_d = cf_q;
        if (!mf_locked) begin
            cf_d.run = '0;
            cf_d.vld = 1'b0;
        end else if (done_i) begin
            if (cf_q.run != '0 && nib_i == cf_q.cand) begin
                if (cf_q.run != RW'(CONF)) cf_d.run = cf_q.run + 1'b1;
            end else begin
                cf_d.cand = nib_i;
                cf_d.run  = RW'(1);
            end
            if (cf_d.run == RW'(CONF)) begin
                cf_d.ql  = cf_d.cand;
                cf_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cf_q <= '0;
        else        cf_q <= cf_d;
    end

    assign ql_o       = cf_q.ql;
    assign ql_valid_o = cf_q.vld;

    a_r6_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cf_q.run <= RW'(CONF));
    a_r6_ql_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ql_o) |-> $past(done_i));
    a_r6_valid_rises_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ql_valid_o) |-> ($past(done_i) && ql_o == $past(nib_i)));
    a_r8_unlock_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_locked |=> !ql_valid_o);
endmodule

// File: rtl/s1_extract.sv
module s1_extract
    import s1x_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ts0_valid,
    input  logic [OCT_W-1:0] ts0_octet,
    input  logic             ts0_nfas,
    input  logic             mf_start,
    input  logic             mf_locked,
    input  logic [SEL_W-1:0] sa_select,
    output logic [S1_W-1:0]  s1_byte,
    output logic             s1_new,
    output logic [QL_W-1:0]  ql,
    output logic             ql_valid
);
    logic            sa_bit;
    logic            smp_en, strt_en, done;
    logic [S1_W-1:0] byte_now;

    assign smp_en  = ts0_valid & ts0_nfas & ~mf_start;
    assign strt_en = ts0_valid & mf_start;

    s1x_sa_pick #(.NUM_SA(SA_COUNT), .TOP_IDX(SA_TOP), .SW(SEL_W)) u_pick (
        .sa_field (ts0_octet[SA_TOP:0]),
        .sel      (sa_select),
        .sa_bit   (sa_bit)
    );

    s1x_assembler #(.SAMPLES(S1_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (smp_en),
        .sample_bit (sa_bit),
        .start_en   (strt_en),
        .mf_locked  (mf_locked),
        .done_o     (done),
        .byte_o     (byte_now),
        .s1_byte_o  (s1_byte),
        .s1_new_o   (s1_new)
    );

    s1x_confirm #(.QW(QL_W), .CONF(CONFIRM_N)) u_conf (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (done),
        .nib_i      (byte_now[QL_W-1:0]),
        .mf_locked  (mf_locked),
        .ql_o       (ql),
        .ql_valid_o (ql_valid)
    );
endmodule

// File: tb/s1_extract_bench.sv
module s1_extract_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ts0_valid = 1'b0;
    logic [7:0] ts0_octet = '0;
    logic       ts0_nfas = 1'b0;
    logic       mf_start = 1'b0;
    logic       mf_locked = 1'b0;
    logic [2:0] sa_select = '0;
    logic [7:0] s1_byte;
    logic       s1_new;
    logic [3:0] ql;
    logic       ql_valid;

    int checks = 0;
    int failures = 0;

    logic [3:0] m_cand = '0;
    int         m_run = 0;
    logic [3:0] m_ql = '0;
    logic       m_vld = 1'b0;
    logic [7:0] m_byte = '0;

    always #4 clk = ~clk;

    s1_extract u_s1_extract (
        .clk(clk), .rst_n(rst_n), .ts0_valid(ts0_valid), .ts0_octet(ts0_octet),
        .ts0_nfas(ts0_nfas), .mf_start(mf_start), .mf_locked(mf_locked),
        .sa_select(sa_select), .s1_byte(s1_byte), .s1_new(s1_new),
        .ql(ql), .ql_valid(ql_valid)
    );

    function automatic int sa_index(input logic [2:0] sel);
        return (sel > 3'd4) ? 4 : 4 - int'(sel);
    endfunction

    function automatic int next_run(input int run, input logic [3:0] cand,
                                    input logic [3:0] nib);
        if (run != 0 && nib == cand) return (run >= 3) ? 3 : run + 1;
        return 1;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_byte(input logic [7:0] b);
        m_run  = next_run(m_run, m_cand, b[3:0]);
        m_cand = b[3:0];
        m_byte = b;
        if (m_run == 3) begin
            m_ql  = m_cand;
            m_vld = 1'b1;
        end
    endtask

    task automatic gap();
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] oct, input logic nf, input logic ms);
        ts0_valid = 1'b1; ts0_octet = oct; ts0_nfas = nf; mf_start = ms;
        @(negedge clk);
        ts0_valid = 1'b0; mf_start = 1'b0; ts0_nfas = 1'b0;
    endtask

    // send one multiframe; nsamp < 8 cuts it short
    task automatic send_mf(input logic [7:0] s1, input logic [2:0] sel, input int nsamp);
        logic [7:0] oct;
        sa_select = sel;
        frame(8'($urandom), 1'b0, 1'b1);
        for (int f = 1; f < 16; f++) begin
            gap();
            if (f % 2 == 1) begin
                if (f / 2 >= nsamp) break;
                oct = 8'($urandom);
                oct[sa_index(sel)] = s1[7 - f / 2];
                frame(oct, 1'b1, 1'b0);
            end else begin
                frame(8'($urandom), 1'b0, 1'b0);
            end
        end
        if (nsamp >= 8) begin
            model_byte(s1);
            check("R4 s1_new pulse", {7'd0, s1_new}, 8'd1);
            check("R4/R2/R3 s1_byte", s1_byte, m_byte);
            check("R6/R7 ql_valid", {7'd0, ql_valid}, {7'd0, m_vld});
            if (m_vld) check("R5/R6/R7 ql", {4'd0, ql}, {4'd0, m_ql});
            @(negedge clk);
            check("R4 pulse length", {7'd0, s1_new}, 8'd0);
        end else begin
            @(negedge clk);
            check("R9 s1_byte held", s1_byte, m_byte);
            check("R9 ql_valid held", {7'd0, ql_valid}, {7'd0, m_vld});
            if (m_vld) check("R9 ql held", {4'd0, ql}, {4'd0, m_ql});
        end
    endtask

    task automatic unlock();
        mf_locked = 1'b0;
        for (int i = 0; i < 4; i++) frame(8'($urandom), 1'($urandom), 1'($urandom));
        check("R8 ql_valid low", {7'd0, ql_valid}, 8'd0);
        check("R8 no s1_new", {7'd0, s1_new}, 8'd0);
        m_run = 0;
        m_vld = 1'b0;
        mf_locked = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd17));
        repeat (3) @(negedge clk);
        check("R1 ql_valid", {7'd0, ql_valid}, 8'd0);
        check("R1 s1_new", {7'd0, s1_new}, 8'd0);
        check("R1 s1_byte", s1_byte, 8'd0);
        rst_n = 1'b1;
        mf_locked = 1'b1;
        @(negedge clk);

        // R6: two matching multiframes do not publish, the third does
        send_mf(8'hA2, 3'd0, 8);
        send_mf(8'h52, 3'd0, 8);
        check("R6 not yet after two", {7'd0, ql_valid}, 8'd0);
        send_mf(8'h32, 3'd0, 8);
        check("R6 published on third", {ql_valid, 3'd0, ql}, 8'h82);
        // R7: new nibble held off until confirmed
        send_mf(8'h0B, 3'd4, 8);
        send_mf(8'hFB, 3'd2, 8);
        check("R7 old value kept", {ql_valid, 3'd0, ql}, 8'h82);
        send_mf(8'h1B, 3'd7, 8);
        check("R7 switched on third", {ql_valid, 3'd0, ql}, 8'h8B);
        // R9: truncated multiframe does not break the run
        send_mf(8'h44, 3'd1, 8);
        send_mf(8'h44, 3'd1, 5);
        send_mf(8'h44, 3'd1, 8);
        send_mf(8'h44, 3'd1, 8);
        check("R9 run survives truncation", {ql_valid, 3'd0, ql}, 8'h84);
        // R8
        unlock();
        send_mf(8'h44, 3'd3, 8);
        check("R8 needs reconfirm", {7'd0, ql_valid}, 8'd0);

        for (int n = 0; n < 60; n++) begin
            logic [3:0] nib;
            logic [7:0] s1;
            int pick = $urandom_range(0, 9);
            nib = (pick < 6) ? m_cand : 4'($urandom);
            s1  = {4'($urandom), nib};
            if ($urandom_range(0, 14) == 0) unlock();
            send_mf(s1, 3'($urandom), ($urandom_range(0, 7) == 0) ? $urandom_range(1, 7) : 8);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule